// File: doc/BRIEF.md
# Two-Buffer Local Memory Bank Controller

This controller fronts one DRAM bank belonging to a processing element that sits in a ring of identical elements. Three requesters share the bank: the element that owns it, its north neighbour and its south neighbour. Each requester raises a request with a byte address, a write enable and write data, holds it until it is acknowledged, and then waits for a one-cycle response pulse. Only one access is in flight at a time.

Two open-row buffers sit in front of the array, and each holds a copy of one full row. An access to a row held in either buffer is a hit and finishes quickly. Any other access is a miss. A miss refills whichever buffer was used less recently, and it takes longer. Writes go to the array and to the buffer at the same time, so the buffers never hold data that the array lacks and an eviction needs no write-back. The array is a behavioural memory with a fixed access time.

In the full configuration the bank is 1 MB of 32-bit words. That is ROW_W=10 rows bits and COL_W=8 word bits, which gives 1 KB rows. The defaults are much smaller so that the storage stays small when the block is elaborated.

Top module: `bank_ctrl`

## Requirements
- R1: A byte address splits into three fields. Bits [1:0] are ignored. Bits [COL_W+1:2] give the word within the row. Bits [AW-1:COL_W+2] give the row.
- R2: A read returns the word most recently written to the same word address, whichever port wrote it and whichever buffer or array copy holds it.
- R3: An access to a row held in a valid buffer is a hit. Its response pulse appears HIT_LAT (2) rising edges after the edge that accepts it.
- R4: An access to any other row is a miss. Its response pulse appears MISS_LAT (4) rising edges after the accepting edge.
- R5: A miss refills the less recently used buffer, and any hit or fill makes the buffer it touches the most recently used. Both buffers never hold the same row.
- R6: When the controller is idle, a pending local request (port 0) is acknowledged ahead of the neighbour ports.
- R7: When north (port 1) and south (port 2) both wait and no local request is pending, the one not granted most recently among the two wins. North wins the first such tie after reset.
- R8: ack_o is at most one-hot. It is high only for a port that is requesting, only while no access is in flight, and for exactly one cycle per accepted request.
- R9: Completion raises rsp_valid_o for one cycle, only on the requesting port's bit. rsp_tag_o carries that port's number (0 local, 1 north, 2 south). rsp_data_o carries the read word, or zero for a write.
- R10: After reset no acknowledge or response is active, both buffers are empty, and the first access is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 3 | Request per port (0 local, 1 north, 2 south), held until acknowledged |
| we_i | input | 3 | Write enable per port |
| addr_i | input | 3 x AW | Byte address per port |
| wdata_i | input | 3 x DATA_W | Write data per port |
| ack_o | output | 3 | One-cycle acknowledge; the request is taken at the next rising edge |
| rsp_valid_o | output | 3 | One-cycle completion pulse on the requesting port |
| rsp_tag_o | output | 2 | Number of the port the response belongs to |
| rsp_data_o | output | DATA_W | Read data, zero for writes |

## Verification
The checker watches the handshake rules on every cycle: acknowledges that are one-hot, only while idle and only to requesters, local priority, north/south alternation, hit and miss latency counted from acceptance, response pulses that match their tag, and two buffers that never hold the same row. Data correctness cannot be seen cycle by cycle. Neither can the choice of which buffer a miss evicts or how byte-address bits are treated. The bench shows these through sweeps that write and read back every word, a row ping-pong pattern that probes LRU replacement through the latencies it observes, and contention rounds against its own arithmetic model of the bank.

// File: rtl/bank_pkg.sv
package bank_pkg;

  localparam int NPORT = 3;

  typedef enum logic [1:0] {
    PORT_LOCAL = 2'd0,
    PORT_NORTH = 2'd1,
    PORT_SOUTH = 2'd2
  } port_e;

  // one-hot grant vector to port number
  function automatic logic [1:0] oh_to_port(input logic [NPORT-1:0] oh);
    logic [1:0] p;
    p = 2'd0;
    for (int i = 0; i < NPORT; i++)
      if (oh[i]) p = 2'(i);
    return p;
  endfunction

  // port number to one-hot
  function automatic logic [NPORT-1:0] port_to_oh(input logic [1:0] p);
    return NPORT'(3'b001 << p);
  endfunction

endpackage

// File: rtl/bank_arb.sv
module bank_arb
  import bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic [NPORT-1:0] req,
  output logic [NPORT-1:0] gnt
);

  logic south_turn_q;  // 1: south wins the next north/south tie

  always_comb begin
    gnt = '0;
    if (idle) begin
      if (req[PORT_LOCAL])
        gnt[PORT_LOCAL] = 1'b1;
      else if (req[PORT_NORTH] && req[PORT_SOUTH])
        gnt = south_turn_q ? 3'b100 : 3'b010;
      else if (req[PORT_NORTH])
        gnt[PORT_NORTH] = 1'b1;
      else if (req[PORT_SOUTH])
        gnt[PORT_SOUTH] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                south_turn_q <= 1'b0;
    else if (gnt[PORT_NORTH])  south_turn_q <= 1'b1;
    else if (gnt[PORT_SOUTH])  south_turn_q <= 1'b0;
  end

endmodule

// File: rtl/bank_array.sv
module bank_array #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_line [1<<COL_W]
);

  localparam int ROWS  = 1 << ROW_W;
  localparam int WORDS = 1 << COL_W;

  logic [DATA_W-1:0] mem_q [ROWS][WORDS];

  always_ff @(posedge clk)
    if (wr_en) mem_q[wr_row][wr_col] <= wr_data;

  always_comb
    for (int w = 0; w < WORDS; w++)
      rd_line[w] = mem_q[rd_row][w];

endmodule

// File: rtl/bank_rowbuf.sv
module bank_rowbuf #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup
  input  logic [ROW_W-1:0]  lk_row,
  output logic              lk_hit,
  output logic              lk_idx,
  // fill from array
  input  logic              fill_en,
  input  logic              fill_idx,
  input  logic [ROW_W-1:0]  fill_row,
  input  logic [DATA_W-1:0] fill_line [1<<COL_W],
  // write-through word update
  input  logic              wr_en,
  input  logic              wr_idx,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  // recency update
  input  logic              touch_en,
  input  logic              touch_idx,
  // read
  input  logic              rd_idx,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data,
  // state for checking
  output logic [1:0]        vld_o,
  output logic [ROW_W-1:0]  tag_o [2]
);

  localparam int WORDS = 1 << COL_W;

  logic [1:0]        vld_q;
  logic [ROW_W-1:0]  tag_q [2];
  logic              lru_q;
  logic [DATA_W-1:0] line_q [2][WORDS];
  logic [1:0]        way_hit;

  for (genvar b = 0; b < 2; b++) begin : g_way
    assign way_hit[b] = vld_q[b] && (tag_q[b] == lk_row);
  end

  assign lk_hit = |way_hit;
  assign lk_idx = way_hit[0] ? 1'b0 : (way_hit[1] ? 1'b1 : lru_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      tag_q[0] <= '0;
      tag_q[1] <= '0;
      lru_q    <= 1'b0;
    end else begin
      if (fill_en) begin
        vld_q[fill_idx] <= 1'b1;
        tag_q[fill_idx] <= fill_row;
      end
      if (touch_en) lru_q <= ~touch_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en)
      for (int w = 0; w < WORDS; w++)
        line_q[fill_idx][w] <= fill_line[w];
    if (wr_en) line_q[wr_idx][wr_col] <= wr_data;
  end

  assign rd_data = line_q[rd_idx][rd_col];
  assign vld_o   = vld_q;
  assign tag_o   = tag_q;

endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_pkg::*;
#(
  parameter int ROW_W    = 4,
  parameter int COL_W    = 4,
  parameter int DATA_W   = 32,
  parameter int HIT_LAT  = 2,
  parameter int MISS_LAT = 4,
  localparam int AW      = ROW_W + COL_W + 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             req_i,
  input  logic [NPORT-1:0]             we_i,
  input  logic [NPORT-1:0][AW-1:0]     addr_i,
  input  logic [NPORT-1:0][DATA_W-1:0] wdata_i,
  output logic [NPORT-1:0]             ack_o,
  output logic [NPORT-1:0]             rsp_valid_o,
  output logic [1:0]                   rsp_tag_o,
  output logic [DATA_W-1:0]            rsp_data_o
);

  localparam int WORDS = 1 << COL_W;
  localparam int CNT_W = $clog2(MISS_LAT + 1);

  function automatic logic [ROW_W-1:0] row_of(input logic [AW-1:0] a);
    return a[AW-1 -: ROW_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [AW-1:0] a);
    return a[COL_W+1:2];
  endfunction

  // request in flight
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        cur_port_q;
  logic              cur_we_q;
  logic [ROW_W-1:0]  cur_row_q;
  logic [COL_W-1:0]  cur_col_q;
  logic [DATA_W-1:0] cur_wdata_q;
  logic              cur_hit_q;
  logic              cur_buf_q;

  // named events
  logic              accept;
  logic              complete;
  logic              acc_hit;
  logic              acc_idx;
  logic [1:0]        acc_port;
  logic [NPORT-1:0]  gnt;
  logic [AW-1:0]     acc_addr;
  logic              acc_we;
  logic [DATA_W-1:0] acc_wdata;

  logic [DATA_W-1:0] arr_line [WORDS];
  logic [DATA_W-1:0] buf_rdata;
  logic [1:0]        buf_vld;
  logic [ROW_W-1:0]  buf_tag [2];

  bank_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .idle  (!busy_q),
    .req   (req_i),
    .gnt   (gnt)
  );

  always_comb begin
    acc_addr  = '0;
    acc_we    = 1'b0;
    acc_wdata = '0;
    for (int i = 0; i < NPORT; i++)
      if (gnt[i]) begin
        acc_addr  = addr_i[i];
        acc_we    = we_i[i];
        acc_wdata = wdata_i[i];
      end
  end

  assign accept   = |gnt;
  assign acc_port = oh_to_port(gnt);
  assign complete = busy_q && (cnt_q == CNT_W'(1));
  assign ack_o    = gnt;

  bank_rowbuf #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_rowbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_row    (row_of(acc_addr)),
    .lk_hit    (acc_hit),
    .lk_idx    (acc_idx),
    .fill_en   (complete && !cur_hit_q),
    .fill_idx  (cur_buf_q),
    .fill_row  (cur_row_q),
    .fill_line (arr_line),
    .wr_en     (complete && cur_we_q),
    .wr_idx    (cur_buf_q),
    .wr_col    (cur_col_q),
    .wr_data   (cur_wdata_q),
    .touch_en  (complete),
    .touch_idx (cur_buf_q),
    .rd_idx    (cur_buf_q),
    .rd_col    (cur_col_q),
    .rd_data   (buf_rdata),
    .vld_o     (buf_vld),
    .tag_o     (buf_tag)
  );

  bank_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .wr_en   (complete && cur_we_q),
    .wr_row  (cur_row_q),
    .wr_col  (cur_col_q),
    .wr_data (cur_wdata_q),
    .rd_row  (cur_row_q),
    .rd_line (arr_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      cur_port_q  <= '0;
      cur_we_q    <= 1'b0;
      cur_row_q   <= '0;
      cur_col_q   <= '0;
      cur_wdata_q <= '0;
      cur_hit_q   <= 1'b0;
      cur_buf_q   <= 1'b0;
    end else if (accept) begin
      busy_q      <= 1'b1;
      cnt_q       <= acc_hit ? CNT_W'(HIT_LAT) : CNT_W'(MISS_LAT);
      cur_port_q  <= acc_port;
      cur_we_q    <= acc_we;
      cur_row_q   <= row_of(acc_addr);
      cur_col_q   <= col_of(acc_addr);
      cur_wdata_q <= acc_wdata;
      cur_hit_q   <= acc_hit;
      cur_buf_q   <= acc_idx;
    end else if (complete) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= '0;
      rsp_tag_o   <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= complete ? port_to_oh(cur_port_q) : '0;
      if (complete) begin
        rsp_tag_o  <= cur_port_q;
        rsp_data_o <= cur_we_q  ? '0 :
                      cur_hit_q ? buf_rdata : arr_line[cur_col_q];
      end
    end
  end

endmodule

// File: rtl/bank_ctrl_chk.sv
module bank_ctrl_chk #(
  parameter int ROW_W    = 4,
  parameter int HIT_LAT  = 2,
  parameter int MISS_LAT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       req_i,
  input logic [2:0]       ack_o,
  input logic [2:0]       rsp_valid_o,
  input logic [1:0]       rsp_tag_o,
  input logic             busy_q,
  input logic             accept,
  input logic             complete,
  input logic             acc_hit,
  input logic [1:0]       buf_vld,
  input logic [ROW_W-1:0] buf_tag [2]
);

  logic [7:0] since_q;
  logic       hit_c_q;
  logic [2:0] port_c_q;
  logic       last_north_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q      <= '0;
      hit_c_q      <= 1'b0;
      port_c_q     <= '0;
      last_north_q <= 1'b0;
    end else begin
      if (accept) begin
        since_q  <= 8'd1;
        hit_c_q  <= acc_hit;
        port_c_q <= ack_o;
      end else if (busy_q && since_q != 8'hff) begin
        since_q <= since_q + 8'd1;
      end
      if (ack_o[1])      last_north_q <= 1'b1;
      else if (ack_o[2]) last_north_q <= 1'b0;
    end
  end

  p_ack_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));
  p_ack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (ack_o == 3'b000));
  p_ack_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_o & ~req_i) == 3'b000));
  p_local_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && req_i[0]) |-> ack_o[0]);
  p_ns_alternate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !req_i[0] && req_i[1] && req_i[2]) |->
      (last_north_q ? ack_o[2] : ack_o[1]));
  p_hit_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && hit_c_q) |-> (since_q == 8'(HIT_LAT)));
  p_miss_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && !hit_c_q) |-> (since_q == 8'(MISS_LAT)));
  p_rsp_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> (rsp_valid_o == $past(port_c_q)));
  p_rsp_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid_o) |-> (rsp_valid_o == (3'b001 << rsp_tag_o)));
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid_o) |=> (rsp_valid_o == 3'b000));
  p_rows_distinct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_vld == 2'b11) |-> (buf_tag[0] != buf_tag[1]));

endmodule

bind bank_ctrl bank_ctrl_chk #(
  .ROW_W(ROW_W), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)
) u_chk (.*);

// File: tb/bank_ctrl_bench.sv
module bank_ctrl_bench;

  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;
  localparam int DATA_W = 32;
  localparam int AW     = ROW_W + COL_W + 2;
  localparam int WORDS  = 1 << COL_W;
  localparam int NW     = (1 << ROW_W) * WORDS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]             req = '0;
  logic [2:0]             we = '0;
  logic [2:0][AW-1:0]     addr = '0;
  logic [2:0][DATA_W-1:0] wdata = '0;
  logic [2:0]             ack;
  logic [2:0]             rsp_valid;
  logic [1:0]             rsp_tag;
  logic [DATA_W-1:0]      rsp_data;

  int tests = 0;
  int fails = 0;

  // bench model of the bank
  logic [DATA_W-1:0] mem_m [NW];
  int  tag_m [2];
  bit  vld_m [2];
  int  lru_m = 0;
  bit  south_next_m = 0;

  always #10 clk = ~clk;  // 50 MHz

  bank_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rsp_valid_o(rsp_valid),
    .rsp_tag_o(rsp_tag), .rsp_data_o(rsp_data)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int w, input int salt);
    return DATA_W'(w * 32'h9E37_79B1 + salt * 32'h0101_0101) ^ 32'h5A5A_0000;
  endfunction

  function automatic int buf_of(input int row);
    for (int b = 0; b < 2; b++)
      if (vld_m[b] && tag_m[b] == row) return b;
    return -1;
  endfunction

  task automatic model_commit(input int p, input bit w, input int row,
                              input int col, input logic [DATA_W-1:0] d);
    int b;
    b = buf_of(row);
    if (b < 0) begin
      b = lru_m;
      tag_m[b] = row;
      vld_m[b] = 1'b1;
    end
    lru_m = 1 - b;
    if (w) mem_m[row * WORDS + col] = d;
    if (p == 1) south_next_m = 1'b1;
    if (p == 2) south_next_m = 1'b0;
  endtask

  // one access alone on port p; checks ack, latency, response and data
  task automatic access(input int p, input bit w, input int word,
                        input int bytesel, input logic [DATA_W-1:0] d,
                        input string rq);
    int row, col, lat, exp_lat;
    logic [DATA_W-1:0] exp_d;
    row = word / WORDS;
    col = word % WORDS;
    exp_lat = (buf_of(row) >= 0) ? 2 : 4;
    exp_d = w ? '0 : mem_m[word];
    @(negedge clk);
    req[p]   = 1'b1;
    we[p]    = w;
    addr[p]  = AW'((word << 2) | (bytesel & 3));
    wdata[p] = d;
    #1;
    while (ack == 3'b000) begin @(negedge clk); #1; end
    chk(ack == 3'(1 << p), "R8", "ack port", ack, 1 << p);
    @(negedge clk);
    req[p] = 1'b0;
    lat = 0;
    while (rsp_valid == 3'b000) begin @(negedge clk); lat++; end
    chk(lat == exp_lat, exp_lat == 2 ? "R3" : "R4", "latency", lat, exp_lat);
    chk(rsp_valid == 3'(1 << p), "R9", "rsp port", rsp_valid, 1 << p);
    chk(rsp_tag == 2'(p), "R9", "rsp tag", rsp_tag, p);
    chk(rsp_data == exp_d, rq, "rsp data", rsp_data, exp_d);
    @(negedge clk);
    chk(rsp_valid == 3'b000, "R9", "rsp one cycle", rsp_valid, 0);
    model_commit(p, w, row, col, d);
  endtask

  // several ports request reads at once; checks grant order
  task automatic contend(input logic [2:0] mask, input int base_word,
                         input string rq);
    logic [2:0] pend;
    int g, exp_g;
    pend = mask;
    @(negedge clk);
    for (int p = 0; p < 3; p++)
      if (mask[p]) begin
        req[p] = 1'b1; we[p] = 1'b0;
        addr[p] = AW'((base_word + p) << 2);
      end
    while (pend != 3'b000) begin
      #1;
      while (ack == 3'b000) begin @(negedge clk); #1; end
      if (pend[0])                exp_g = 0;
      else if (pend[1] && pend[2]) exp_g = south_next_m ? 2 : 1;
      else                        exp_g = pend[1] ? 1 : 2;
      g = ack[0] ? 0 : (ack[1] ? 1 : 2);
      chk(g == exp_g, rq, "grant order", g, exp_g);
      @(negedge clk);
      req[g] = 1'b0;
      pend[g] = 1'b0;
      while (rsp_valid == 3'b000) @(negedge clk);
      chk(rsp_tag == 2'(g), "R9", "contend tag", rsp_tag, g);
      chk(rsp_data == mem_m[base_word + g], "R2", "contend data",
          rsp_data, mem_m[base_word + g]);
      model_commit(g, 1'b0, (base_word + g) / WORDS, (base_word + g) % WORDS, '0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog all: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    vld_m[0] = 0; vld_m[1] = 0; tag_m[0] = 0; tag_m[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: idle after reset
    chk(ack == 3'b000, "R10", "ack after reset", ack, 0);
    chk(rsp_valid == 3'b000, "R10", "rsp after reset", rsp_valid, 0);

    // R1 R2 R10: write every word, varying port and ignored byte bits;
    // the first write is a miss because buffers are empty
    for (int w = 0; w < NW; w++)
      access(w % 3, 1'b1, w, w, pat(w, 0), "R10");

    // R1 R2: read everything back in reverse with other byte bits
    for (int w = NW - 1; w >= 0; w--)
      access((w + 1) % 3, 1'b0, w, 3 - (w & 3), '0, "R1");

    // R5: ping-pong between two rows keeps both resident, third evicts LRU
    access(0, 1'b0, 0 * WORDS + 1, 0, '0, "R5");
    access(1, 1'b0, 5 * WORDS + 2, 0, '0, "R5");
    access(2, 1'b0, 0 * WORDS + 3, 0, '0, "R5");
    access(0, 1'b0, 5 * WORDS + 4, 0, '0, "R5");
    access(1, 1'b0, 9 * WORDS + 5, 0, '0, "R5");   // evicts row 0
    access(2, 1'b0, 5 * WORDS + 6, 0, '0, "R5");   // still a hit
    access(0, 1'b0, 0 * WORDS + 7, 0, '0, "R5");   // miss again

    // R2: write-through on hit and miss, read back from other ports
    access(1, 1'b1, 5 * WORDS + 6, 0, pat(7, 3), "R2");
    access(2, 1'b0, 5 * WORDS + 6, 1, '0, "R2");
    access(0, 1'b1, 12 * WORDS + 0, 2, pat(9, 4), "R2");
    access(1, 1'b0, 12 * WORDS + 0, 3, '0, "R2");
    access(2, 1'b0, 3 * WORDS + 8, 0, '0, "R2");
    access(0, 1'b0, 7 * WORDS + 8, 0, '0, "R2");
    access(1, 1'b0, 12 * WORDS + 0, 0, '0, "R2");

    // R6 R7: contention
    contend(3'b111, 20, "R6");
    contend(3'b110, 40, "R7");
    contend(3'b110, 60, "R7");
    contend(3'b101, 80, "R6");
    access(2, 1'b0, 100, 0, '0, "R7");
    contend(3'b110, 120, "R7");
    contend(3'b011, 140, "R6");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule